// File: doc/BRIEF.md
# Single-Precision Floating-Point Adder

This block adds or subtracts two 32-bit binary floating-point operands and returns the packed 32-bit result together with four exception flags. Each operand holds a sign bit in bit 31, an 8-bit biased exponent (bias 127) in bits 30:23 and a 23-bit fraction in bits 22:0. A nonzero exponent field adds a hidden leading 1, which gives a 24-bit significand. The whole datapath is combinational and is followed by one output register, so a result appears one clock after its operands are presented.

The datapath decodes both operands and selects the operand with the larger magnitude. It shifts the other significand right by the exponent difference, keeping three extra low bits and folding every bit shifted out into the lowest one. It then adds or subtracts the significands, normalizes the result and rounds it in one of four selectable modes. Subnormal operands and results use gradual underflow; nothing is flushed to zero. Signed zeros, infinities and NaNs follow the usual rules, and every NaN result is the canonical quiet pattern.

Top module: `fp32_add_unit`

## Requirements
- R1: For finite operands, `res_o` is the correctly rounded value of `a_i + b_i` when `sub_i` is 0, and of `a_i - b_i` when `sub_i` is 1. Subtraction is done by inverting the sign of `b_i`.
- R2: An exponent field of 0 is decoded as a subnormal operand, with a hidden bit of 0 and an effective exponent of -126. A result below 2^-126 is returned as a subnormal, not as zero. A subnormal sum that reaches 2^-126 carries into exponent field 1.
- R3: Bits shifted out during alignment take part in rounding. Bits beyond the guard position are ORed into a sticky bit, so a shift of 27 or more places still leaves an inexact result.
- R4: With `rmode_i` = 0 (round to nearest), an exact halfway case rounds to the neighbour whose fraction LSB is 0.
- R5: `rmode_i` = 1 truncates toward zero, 2 rounds toward +infinity and 3 rounds toward -infinity. `inexact_o` is set whenever any discarded bit is nonzero.
- R6: Any NaN operand gives the result 0x7FC00000. A quiet NaN operand (fraction bit 22 set) leaves `invalid_o` clear.
- R7: An infinite operand passes through with its effective sign, and no flag is set. Infinities of opposite effective sign give 0x7FC00000 with `invalid_o` set.
- R8: A signaling NaN operand (exponent field 0xFF, fraction nonzero, fraction bit 22 clear) sets `invalid_o`.
- R9: When the rounded magnitude is larger than 0x7F7FFFFF, `overflow_o` and `inexact_o` are set. The result is infinity in mode 0, in mode 2 for a positive result and in mode 3 for a negative result. In every other case it is the largest finite value with the result's sign. Whether overflow occurs depends on the rounding done in the selected mode.
- R10: An exactly zero sum of operands with opposite effective signs is +0 in every mode except mode 3, which gives -0. Two zeros with the same effective sign keep that sign.
- R11: `underflow_o` is set exactly when the result is a nonzero subnormal. `inexact_o` stays clear when that subnormal is exact.
- R12: While `rst_ni` is low, every output is 0. Otherwise the outputs show the result of the operands sampled at the previous rising clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| a_i | input | 32 | First operand |
| b_i | input | 32 | Second operand |
| sub_i | input | 1 | 1 selects subtraction (`a_i - b_i`) |
| rmode_i | input | 2 | Rounding mode: 0 nearest-even, 1 toward zero, 2 toward +inf, 3 toward -inf |
| res_o | output | 32 | Packed result |
| invalid_o | output | 1 | Invalid operation flag |
| overflow_o | output | 1 | Overflow flag |
| underflow_o | output | 1 | Nonzero subnormal result flag |
| inexact_o | output | 1 | Rounded result differs from the exact value |

## Verification
The hardest case to reach is an overflow caused only by rounding. Here the aligned sum is still finite, but the rounding increment carries out of the significand and pushes the exponent to 0xFF. The stimulus adds the largest finite value to an operand exactly 24 binades below it, which sets the guard bit and nothing else. That makes an exact tie with an odd LSB: nearest-even rounding carries into overflow, while truncation in the same cycle pattern must not flag overflow. Two other crossings get directed pairs: a subnormal sum that reaches the smallest normal, and massive cancellation clamped at the minimum exponent.

// File: rtl/fp32_add_pkg.sv
package fp32_add_pkg;
  localparam int EXP_W   = 8;
  localparam int FRAC_W  = 23;
  localparam int WORD_W  = 1 + EXP_W + FRAC_W;
  localparam int SIG_W   = FRAC_W + 1;
  localparam int EXT_W   = SIG_W + 3;          // significand plus guard, round, sticky
  localparam int EXP_MAX = (1 << EXP_W) - 1;

  localparam logic [WORD_W-1:0] QNAN_WORD = {1'b0, {EXP_W{1'b1}}, 1'b1, {(FRAC_W-1){1'b0}}};

  typedef enum logic [1:0] {
    RM_RNE = 2'd0,
    RM_RTZ = 2'd1,
    RM_RUP = 2'd2,
    RM_RDN = 2'd3
  } rmode_e;

  typedef struct packed {
    logic             sign;
    logic [EXP_W-1:0] exp_eff;
    logic [SIG_W-1:0] sig;
    logic             is_zero;
    logic             is_inf;
    logic             is_nan;
    logic             is_snan;
  } opnd_t;
endpackage

// File: rtl/fp32_unpack.sv
module fp32_unpack
  import fp32_add_pkg::*;
(
  input  logic [WORD_W-1:0] word_i,
  input  logic              flip_i,
  output opnd_t             op_o
);
  logic [EXP_W-1:0]  exp_f;
  logic [FRAC_W-1:0] frac_f;
  logic              exp_zero, exp_ones, frac_zero;

  assign exp_f     = word_i[WORD_W-2 -: EXP_W];
  assign frac_f    = word_i[FRAC_W-1:0];
  assign exp_zero  = (exp_f == '0);
  assign exp_ones  = (exp_f == EXP_W'(EXP_MAX));
  assign frac_zero = (frac_f == '0);

  always_comb begin
    op_o.sign    = word_i[WORD_W-1] ^ flip_i;
    op_o.exp_eff = exp_zero ? EXP_W'(1) : exp_f;   // subnormals share the minimum exponent
    op_o.sig     = {~exp_zero, frac_f};
    op_o.is_zero = exp_zero & frac_zero;
    op_o.is_inf  = exp_ones & frac_zero;
    op_o.is_nan  = exp_ones & ~frac_zero;
    op_o.is_snan = exp_ones & ~frac_zero & ~frac_f[FRAC_W-1];
  end
endmodule

// File: rtl/fp32_align_add.sv
module fp32_align_add
  import fp32_add_pkg::*;
(
  input  opnd_t            a_i,
  input  opnd_t            b_i,
  output logic [EXT_W:0]   sum_o,
  output logic [EXP_W-1:0] exp_o,
  output logic             sign_o,
  output logic             eff_sub_o
);
  opnd_t            x, y;
  logic [EXP_W-1:0] diff;
  logic [EXT_W-1:0] x_ext, y_ext, y_shr, lost_mask, y_aln;
  logic             sticky;

  always_comb begin
    if ({a_i.exp_eff, a_i.sig} >= {b_i.exp_eff, b_i.sig}) begin
      x = a_i;
      y = b_i;
    end else begin
      x = b_i;
      y = a_i;
    end
    diff      = x.exp_eff - y.exp_eff;
    x_ext     = {x.sig, 3'b000};
    y_ext     = {y.sig, 3'b000};
    y_shr     = y_ext >> diff;
    lost_mask = (diff >= EXP_W'(EXT_W)) ? '1
              : ((EXT_W'(1) << diff) - EXT_W'(1));
    sticky    = |(y_ext & lost_mask);
    y_aln     = {y_shr[EXT_W-1:1], y_shr[0] | sticky};
    eff_sub_o = a_i.sign ^ b_i.sign;
    sum_o     = eff_sub_o ? ({1'b0, x_ext} - {1'b0, y_aln})
                          : ({1'b0, x_ext} + {1'b0, y_aln});
    exp_o     = x.exp_eff;
    sign_o    = x.sign;
  end
endmodule

// File: rtl/fp32_norm_round.sv
module fp32_norm_round
  import fp32_add_pkg::*;
(
  input  logic [EXT_W:0]    sum_i,
  input  logic [EXP_W-1:0]  exp_i,
  input  logic              sign_i,
  input  logic              eff_sub_i,
  input  rmode_e            rmode_i,
  output logic [WORD_W-1:0] res_o,
  output logic              overflow_o,
  output logic              underflow_o,
  output logic              inexact_o
);
  localparam int LZW = $clog2(EXT_W + 1);
  localparam int EW  = EXP_W + 2;

  function automatic logic [LZW-1:0] lead_zeros(input logic [EXT_W-1:0] v);
    logic [LZW-1:0] n;
    logic           hit;
    n   = '0;
    hit = 1'b0;
    for (int k = EXT_W - 1; k >= 0; k--) begin
      if (!hit) begin
        if (v[k]) hit = 1'b1;
        else      n   = n + 1'b1;
      end
    end
    return n;
  endfunction

  logic [EXT_W-1:0]  m;
  logic [EW-1:0]     e_n, e_f, lim, sh;
  logic [SIG_W-1:0]  keep;
  logic [SIG_W:0]    rnd;
  logic [FRAC_W-1:0] frac;
  logic              g, st, inc, ovf, to_inf;

  always_comb begin
    lim = EW'(exp_i) - EW'(1);
    sh  = (EW'(lead_zeros(sum_i[EXT_W-1:0])) < lim) ? EW'(lead_zeros(sum_i[EXT_W-1:0])) : lim;
    if (sum_i[EXT_W]) begin
      m   = {sum_i[EXT_W:2], |sum_i[1:0]};
      e_n = EW'(exp_i) + EW'(1);
    end else begin
      // left shift stops at the minimum exponent: result stays subnormal
      m   = sum_i[EXT_W-1:0] << sh;
      e_n = EW'(exp_i) - sh;
    end
    keep = m[EXT_W-1:3];
    g    = m[2];
    st   = |m[1:0];
    unique case (rmode_i)
      RM_RNE:  inc = g & (st | keep[0]);
      RM_RTZ:  inc = 1'b0;
      RM_RUP:  inc = ~sign_i & (g | st);
      default: inc = sign_i & (g | st);
    endcase
    rnd = {1'b0, keep} + {{SIG_W{1'b0}}, inc};
    if (rnd[SIG_W]) begin
      e_f  = e_n + EW'(1);
      frac = '0;
    end else begin
      e_f  = rnd[SIG_W-1] ? e_n : '0;
      frac = rnd[FRAC_W-1:0];
    end
    ovf    = (e_f >= EW'(EXP_MAX));
    to_inf = (rmode_i == RM_RNE) | ((rmode_i == RM_RUP) & ~sign_i)
           | ((rmode_i == RM_RDN) & sign_i);

    overflow_o  = 1'b0;
    underflow_o = 1'b0;
    inexact_o   = 1'b0;
    if (sum_i == '0) begin
      res_o = {(eff_sub_i ? (rmode_i == RM_RDN) : sign_i), {(WORD_W-1){1'b0}}};
    end else if (ovf) begin
      overflow_o = 1'b1;
      inexact_o  = 1'b1;
      res_o = to_inf ? {sign_i, {EXP_W{1'b1}}, {FRAC_W{1'b0}}}
                     : {sign_i, EXP_W'(EXP_MAX - 1), {FRAC_W{1'b1}}};
    end else begin
      underflow_o = (e_f == '0);
      inexact_o   = g | st;
      res_o       = {sign_i, e_f[EXP_W-1:0], frac};
    end
  end
endmodule

// File: rtl/fp32_add_unit.sv
module fp32_add_unit
  import fp32_add_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic [31:0] a_i,
  input  logic [31:0] b_i,
  input  logic        sub_i,
  input  logic [1:0]  rmode_i,
  output logic [31:0] res_o,
  output logic        invalid_o,
  output logic        overflow_o,
  output logic        underflow_o,
  output logic        inexact_o
);
  logic [1:0][WORD_W-1:0] word_v;
  logic [1:0]             flip_v;
  opnd_t                  op_v [2];

  assign word_v = {b_i, a_i};
  assign flip_v = {sub_i, 1'b0};

  for (genvar i = 0; i < 2; i++) begin : g_unpack
    fp32_unpack u_unpack (
      .word_i (word_v[i]),
      .flip_i (flip_v[i]),
      .op_o   (op_v[i])
    );
  end

  logic [EXT_W:0]    sum;
  logic [EXP_W-1:0]  sum_exp;
  logic              sum_sign, eff_sub;
  logic [WORD_W-1:0] fin_res;
  logic              fin_ovf, fin_ufl, fin_inx;

  fp32_align_add u_align (
    .a_i       (op_v[0]),
    .b_i       (op_v[1]),
    .sum_o     (sum),
    .exp_o     (sum_exp),
    .sign_o    (sum_sign),
    .eff_sub_o (eff_sub)
  );

  fp32_norm_round u_round (
    .sum_i       (sum),
    .exp_i       (sum_exp),
    .sign_i      (sum_sign),
    .eff_sub_i   (eff_sub),
    .rmode_i     (rmode_e'(rmode_i)),
    .res_o       (fin_res),
    .overflow_o  (fin_ovf),
    .underflow_o (fin_ufl),
    .inexact_o   (fin_inx)
  );

  logic [WORD_W-1:0] res_d;
  logic              inv_d, ovf_d, ufl_d, inx_d, inf_clash;

  always_comb begin
    inf_clash = op_v[0].is_inf & op_v[1].is_inf & (op_v[0].sign ^ op_v[1].sign);
    inv_d = inf_clash | op_v[0].is_snan | op_v[1].is_snan;
    ovf_d = 1'b0;
    ufl_d = 1'b0;
    inx_d = 1'b0;
    if (op_v[0].is_nan | op_v[1].is_nan | inf_clash) begin
      res_d = QNAN_WORD;
    end else if (op_v[0].is_inf) begin
      res_d = {op_v[0].sign, {EXP_W{1'b1}}, {FRAC_W{1'b0}}};
    end else if (op_v[1].is_inf) begin
      res_d = {op_v[1].sign, {EXP_W{1'b1}}, {FRAC_W{1'b0}}};
    end else begin
      res_d = fin_res;
      ovf_d = fin_ovf;
      ufl_d = fin_ufl;
      inx_d = fin_inx;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      res_o       <= '0;
      invalid_o   <= 1'b0;
      overflow_o  <= 1'b0;
      underflow_o <= 1'b0;
      inexact_o   <= 1'b0;
    end else begin
      res_o       <= res_d;
      invalid_o   <= inv_d;
      overflow_o  <= ovf_d;
      underflow_o <= ufl_d;
      inexact_o   <= inx_d;
    end
  end
endmodule

// File: rtl/fp32_add_unit_chk.sv
module fp32_add_unit_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic [31:0] a_i,
  input logic [31:0] b_i,
  input logic        sub_i,
  input logic [1:0]  rmode_i,
  input logic [31:0] res_o,
  input logic        invalid_o,
  input logic        overflow_o,
  input logic        underflow_o,
  input logic        inexact_o
);
  logic seen_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) seen_q <= 1'b0;
    else         seen_q <= 1'b1;
  end

  logic a_nan, b_nan, a_inf, b_inf, b_sgn, self_sub;
  assign a_nan    = (a_i[30:23] == 8'hFF) && (a_i[22:0] != '0);
  assign b_nan    = (b_i[30:23] == 8'hFF) && (b_i[22:0] != '0);
  assign a_inf    = (a_i[30:23] == 8'hFF) && (a_i[22:0] == '0);
  assign b_inf    = (b_i[30:23] == 8'hFF) && (b_i[22:0] == '0);
  assign b_sgn    = b_i[31] ^ sub_i;
  assign self_sub = sub_i && (a_i == b_i) && (a_i[30:23] != 8'hFF) && (rmode_i != 2'd3);

  // R6
  a_r6_nan_canon: assert property (@(posedge clk_i) disable iff (!rst_ni)
    seen_q && $past(a_nan || b_nan) |-> res_o == 32'h7FC00000);

  // R7
  a_r7_inf_clash_invalid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    seen_q && $past(a_inf && b_inf && (a_i[31] != b_sgn)) |-> invalid_o && res_o == 32'h7FC00000);

  // R9
  a_r9_ovf_inexact: assert property (@(posedge clk_i) disable iff (!rst_ni)
    overflow_o |-> inexact_o);

  // R9
  a_r9_ovf_nearest_inf: assert property (@(posedge clk_i) disable iff (!rst_ni)
    seen_q && overflow_o && ($past(rmode_i) == 2'd0) |-> res_o[30:0] == 31'h7F800000);

  // R10
  a_r10_self_sub_pos_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    seen_q && $past(self_sub) |-> res_o == 32'h0 && !inexact_o);

  // R11
  a_r11_uflow_subnormal: assert property (@(posedge clk_i) disable iff (!rst_ni)
    underflow_o |-> res_o[30:23] == 8'h00 && res_o[22:0] != '0 && !overflow_o);
endmodule

bind fp32_add_unit fp32_add_unit_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .a_i         (a_i),
  .b_i         (b_i),
  .sub_i       (sub_i),
  .rmode_i     (rmode_i),
  .res_o       (res_o),
  .invalid_o   (invalid_o),
  .overflow_o  (overflow_o),
  .underflow_o (underflow_o),
  .inexact_o   (inexact_o)
);

// File: tb/fp32_add_unit_test.sv
`timescale 1ns/1ps
module fp32_add_unit_test;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [31:0] a = '0, b = '0;
  logic        sub = 1'b0;
  logic [1:0]  rm = 2'd0;
  logic [31:0] res;
  logic        inv, ovf, ufl, inx;
  int          n_chk = 0, n_fail = 0;

  localparam logic [1:0] RNE = 2'd0, RTZ = 2'd1, RUP = 2'd2, RDN = 2'd3;
  localparam logic [31:0] ONE = 32'h3F800000, MAXF = 32'h7F7FFFFF, PINF = 32'h7F800000,
                          NINF = 32'hFF800000, QNAN = 32'h7FC00000;

  always #10 clk = ~clk;

  fp32_add_unit uut (
    .clk_i(clk), .rst_ni(rst_ni), .a_i(a), .b_i(b), .sub_i(sub), .rmode_i(rm),
    .res_o(res), .invalid_o(inv), .overflow_o(ovf), .underflow_o(ufl), .inexact_o(inx)
  );

  // flags packed {invalid, overflow, underflow, inexact}
  task automatic check(input string tag, input logic [31:0] er, input logic [3:0] ef);
    n_chk++;
    if (res !== er || {inv, ovf, ufl, inx} !== ef) begin
      n_fail++;
      $display("FAIL %s actual=%h/%b expected=%h/%b", tag, res, {inv, ovf, ufl, inx}, er, ef);
    end
  endtask

  task automatic run(input string tag, input logic [31:0] ta, input logic [31:0] tb_,
                     input logic ts, input logic [1:0] tr,
                     input logic [31:0] er, input logic [3:0] ef);
    @(negedge clk);
    a = ta; b = tb_; sub = ts; rm = tr;
    @(negedge clk);
    check(tag, er, ef);
  endtask

  task automatic t_reset;
    repeat (2) @(negedge clk);
    check("R12 reset state", 32'h0, 4'b0000);
    rst_ni = 1'b1;
  endtask

  task automatic t_latency;
    @(negedge clk);
    a = ONE; b = ONE; sub = 1'b0; rm = RNE;
    #2 check("R12 output held before edge", 32'h0, 4'b0000);
    @(negedge clk);
    check("R12 one cycle latency", 32'h40000000, 4'b0000);
  endtask

  task automatic t_normal;
    run("R1 1+1", ONE, ONE, 1'b0, RNE, 32'h40000000, 4'b0000);
    run("R1 3-1", 32'h40400000, ONE, 1'b1, RNE, 32'h40000000, 4'b0000);
    run("R1 1-(-1)", ONE, 32'hBF800000, 1'b1, RNE, 32'h40000000, 4'b0000);
    run("R1 1.5+(-0.5)", 32'h3FC00000, 32'hBF000000, 1'b0, RNE, ONE, 4'b0000);
    run("R1 cancellation", ONE, 32'h3F7FFFFF, 1'b1, RNE, 32'h33800000, 4'b0000);
  endtask

  task automatic t_subnormal;
    run("R2 tiny+tiny", 32'h1, 32'h1, 1'b0, RNE, 32'h2, 4'b0010);
    run("R2 carry to normal", 32'h007FFFFF, 32'h1, 1'b0, RNE, 32'h00800000, 4'b0000);
    run("R2 normal to subnormal", 32'h00800000, 32'h1, 1'b1, RNE, 32'h007FFFFF, 4'b0010);
  endtask

  task automatic t_sticky;
    run("R3 far operand nearest", ONE, 32'h30800000, 1'b0, RNE, ONE, 4'b0001);
    run("R3 far operand up", ONE, 32'h30800000, 1'b0, RUP, 32'h3F800001, 4'b0001);
    run("R3 above half", ONE, 32'h33C00000, 1'b0, RNE, 32'h3F800001, 4'b0001);
  endtask

  task automatic t_tie;
    run("R4 tie to even stays", ONE, 32'h33800000, 1'b0, RNE, ONE, 4'b0001);
    run("R4 tie to even up", 32'h3F800001, 32'h33800000, 1'b0, RNE, 32'h3F800002, 4'b0001);
  endtask

  task automatic t_modes;
    run("R5 neg toward -inf", 32'hBF800000, 32'hB0800000, 1'b0, RDN, 32'hBF800001, 4'b0001);
    run("R5 neg toward +inf", 32'hBF800000, 32'hB0800000, 1'b0, RUP, 32'hBF800000, 4'b0001);
    run("R5 neg toward zero", 32'hBF800000, 32'hB0800000, 1'b0, RTZ, 32'hBF800000, 4'b0001);
    run("R5 pos toward zero", ONE, 32'h33C00000, 1'b0, RTZ, ONE, 4'b0001);
  endtask

  task automatic t_nan;
    run("R6 quiet nan a", 32'h7FC00001, ONE, 1'b0, RNE, QNAN, 4'b0000);
    run("R6 quiet nan b", ONE, 32'hFFC12345, 1'b1, RNE, QNAN, 4'b0000);
  endtask

  task automatic t_inf;
    run("R7 inf+1", PINF, ONE, 1'b0, RNE, PINF, 4'b0000);
    run("R7 1-inf", ONE, PINF, 1'b1, RNE, NINF, 4'b0000);
    run("R7 inf+inf", PINF, PINF, 1'b0, RNE, PINF, 4'b0000);
    run("R7 inf-inf", PINF, PINF, 1'b1, RNE, QNAN, 4'b1000);
    run("R7 inf+(-inf)", PINF, NINF, 1'b0, RDN, QNAN, 4'b1000);
  endtask

  task automatic t_snan;
    run("R8 signaling a", 32'h7F800001, ONE, 1'b0, RNE, QNAN, 4'b1000);
    run("R8 signaling b", ONE, 32'hFFA00000, 1'b0, RNE, QNAN, 4'b1000);
  endtask

  task automatic t_ovf;
    run("R9 max+max nearest", MAXF, MAXF, 1'b0, RNE, PINF, 4'b0101);
    run("R9 max+max toward zero", MAXF, MAXF, 1'b0, RTZ, MAXF, 4'b0101);
    run("R9 neg toward +inf", 32'hFF7FFFFF, 32'hFF7FFFFF, 1'b0, RUP, 32'hFF7FFFFF, 4'b0101);
    run("R9 neg toward -inf", 32'hFF7FFFFF, 32'hFF7FFFFF, 1'b0, RDN, NINF, 4'b0101);
    run("R9 overflow by rounding", MAXF, 32'h73000000, 1'b0, RNE, PINF, 4'b0101);
    run("R9 no overflow truncating", MAXF, 32'h73000000, 1'b0, RTZ, MAXF, 4'b0001);
  endtask

  task automatic t_zero;
    run("R10 1-1 nearest", ONE, ONE, 1'b1, RNE, 32'h0, 4'b0000);
    run("R10 1-1 toward -inf", ONE, ONE, 1'b1, RDN, 32'h80000000, 4'b0000);
    run("R10 -0+-0", 32'h80000000, 32'h80000000, 1'b0, RNE, 32'h80000000, 4'b0000);
    run("R10 +0+-0 toward +inf", 32'h0, 32'h80000000, 1'b0, RUP, 32'h0, 4'b0000);
    run("R10 0-0 toward -inf", 32'h0, 32'h0, 1'b1, RDN, 32'h80000000, 4'b0000);
  endtask

  task automatic t_uflow;
    run("R11 exact subnormal", 32'h3, 32'h1, 1'b1, RNE, 32'h2, 4'b0010);
    run("R11 normal difference to tiny", 32'h00800001, 32'h00800000, 1'b1, RNE, 32'h1, 4'b0010);
    run("R11 smallest normal no flag", 32'h00800000, 32'h0, 1'b0, RNE, 32'h00800000, 4'b0000);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    t_reset();
    t_latency();
    t_normal();
    t_subnormal();
    t_sticky();
    t_tie();
    t_modes();
    t_nan();
    t_inf();
    t_snan();
    t_ovf();
    t_zero();
    t_uflow();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule